// File: doc/BRIEF.md
# Bit-Banged Serial EEPROM Responder

This block models the target side of a two-wire serial EEPROM holding 256 bytes. It has no bus clock of its own. Each time the host's control logic writes new clock-line and data-line levels, it raises a one-cycle update strobe. The responder compares the new pair with the pair it stored on the previous update. From that comparison it recognises start conditions, stop conditions and rising clock edges. It then moves through one combined phase counter.

The counter runs from 1 to 9 while an 8-bit command byte is shifted in. After the command's acknowledge slot, it shifts in an 8-bit word address. If the command's read bit is set, the responder drives the data line from the previously fetched byte during this phase. When the eighth address bit arrives, the byte at that address is fetched, another acknowledge is armed and the counter returns to idle.

The stored data-line level is what the host reads back. It includes any level the responder forced. The memory image is a parameter, and the contents are read-only.

Top module: `i2c_prom_responder`

## Requirements
- R1: After reset the phase counter is 0, no acknowledge is pending, the command, address and data registers are 0x00, and the stored data level `sda_o` is 1.
- R2: An update with stored clock high, new clock high, stored data 1 and new data 0 is a start condition. It sets the phase counter to 1 and clears the command register, whatever the current phase.
- R3: An update with stored clock high, new clock high, stored data 0 and new data 1 is a stop condition. It leaves the phase counter, command register and acknowledge flag unchanged.
- R4: While the phase counter is 0 and no acknowledge is pending, every update other than a start leaves the counter, command, address and data registers unchanged. `sda_o` follows the new data level.
- R5: A bit is taken only on an update where the stored clock is 0 and the new clock is 1, and the new data level equals the stored one. A rising edge with a changed data level leaves the counter and the registers unchanged.
- R6: In phase counts 1 to 8, each taken bit enters the command register at bit 0, so bits arrive MSB first, and the count advances by one. Reaching count 9 arms an acknowledge.
- R7: On a rising clock edge with an acknowledge pending, `sda_o` becomes 0 and the flag clears. The counter and registers keep their values. This also applies when the counter is 0.
- R8: In phase counts 9 to 16, each taken bit enters the address register at bit 0 and the data register shifts left by one. If command bit 0 is 1 (read), `sda_o` becomes the data register's bit 7 as it was before the shift. Otherwise `sda_o` is the host's level.
- R9: The bit that would take the count to 17 instead loads the data register with the stored byte at the updated address, arms an acknowledge and sets the counter to 0.
- R10: Without the update strobe, changes on the clock and data inputs alter no state.
- R11: With the default image, the byte stored at address a is (7·a + 1) mod 256.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| upd_i | input | 1 | One-cycle strobe: host wrote new line levels |
| scl_i | input | 1 | Clock-line level written by the host |
| sda_i | input | 1 | Data-line level written by the host |
| sda_o | output | 1 | Stored data-line level after any responder override |
| tick_o | output | 5 | Phase counter (debug) |
| ack_pend_o | output | 1 | Acknowledge armed for the next rising clock (debug) |
| cmd_o | output | 8 | Command shift register (debug) |
| addr_o | output | 8 | Address shift register (debug) |
| data_o | output | 8 | Data register (debug) |

## Verification
The bench targets the acknowledge slot that follows the address, where the counter has already returned to 0. A design that let the idle rule win there would never pull the line low. It also targets a rising clock edge with a changed data level, which a careless design would shift in as a bit, and a stop issued in mid-command, which must not rewind the counter. The second read transaction checks that the bits driven out come from the byte fetched by the first transaction. A design that loaded the data register too early, or drove the bit after the shift instead of before it, shows a wrong pattern on `sda_o`.

// File: rtl/i2c_prom_pkg.sv
package i2c_prom_pkg;
  localparam int BYTE_W    = 8;
  localparam int ADDR_W    = 8;
  localparam int MEM_DEPTH = 1 << ADDR_W;
  localparam int TICK_W    = 5;
  localparam int CMD_LAST  = BYTE_W + 1;      // count at which command is complete
  localparam int ADDR_LAST = 2 * BYTE_W + 1;  // count at which address is complete

  typedef enum logic [2:0] {
    EV_NONE,
    EV_START,
    EV_STOP,
    EV_BIT,     // rising clock, data held
    EV_GLITCH   // rising clock, data changed
  } bus_ev_e;

  function automatic logic [MEM_DEPTH*BYTE_W-1:0] default_image();
    logic [MEM_DEPTH*BYTE_W-1:0] img;
    img = '0;
    for (int i = 0; i < MEM_DEPTH; i++) img[i*BYTE_W +: BYTE_W] = BYTE_W'(i * 7 + 1);
    return img;
  endfunction
endpackage

// File: rtl/i2c_prom_cond.sv
module i2c_prom_cond
  import i2c_prom_pkg::*;
(
  input  logic    scl_q_i,
  input  logic    sda_q_i,
  input  logic    scl_i,
  input  logic    sda_i,
  output bus_ev_e ev_o
);
  always_comb begin
    ev_o = EV_NONE;
    if (scl_q_i && scl_i && (sda_q_i != sda_i)) ev_o = sda_i ? EV_STOP : EV_START;
    else if (!scl_q_i && scl_i)                 ev_o = (sda_q_i == sda_i) ? EV_BIT : EV_GLITCH;
  end
endmodule

// File: rtl/i2c_prom_rom.sv
module i2c_prom_rom
  import i2c_prom_pkg::*;
#(
  parameter logic [MEM_DEPTH*BYTE_W-1:0] IMAGE = default_image()
) (
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [BYTE_W-1:0] rd_data_o
);
  logic [BYTE_W-1:0] rom [MEM_DEPTH];

  for (genvar g = 0; g < MEM_DEPTH; g++) begin : g_word
    assign rom[g] = IMAGE[g*BYTE_W +: BYTE_W];
  end

  assign rd_data_o = rom[rd_addr_i];
endmodule

// File: rtl/i2c_prom_responder.sv
module i2c_prom_responder
  import i2c_prom_pkg::*;
#(
  parameter logic [MEM_DEPTH*BYTE_W-1:0] IMAGE = default_image()
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              upd_i,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_o,
  output logic [TICK_W-1:0] tick_o,
  output logic              ack_pend_o,
  output logic [BYTE_W-1:0] cmd_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [BYTE_W-1:0] data_o
);
  logic              scl_q, sda_q, ack_q;
  logic [TICK_W-1:0] tick_q;
  logic [BYTE_W-1:0] cmd_q, data_q;
  logic [ADDR_W-1:0] addr_q;

  logic              sda_d, ack_d;
  logic [TICK_W-1:0] tick_d;
  logic [BYTE_W-1:0] cmd_d, data_d;
  logic [ADDR_W-1:0] addr_d, addr_shift;
  logic [BYTE_W-1:0] rom_byte;
  bus_ev_e           ev;

  i2c_prom_cond u_cond (
    .scl_q_i(scl_q), .sda_q_i(sda_q), .scl_i(scl_i), .sda_i(sda_i), .ev_o(ev)
  );

  assign addr_shift = {addr_q[ADDR_W-2:0], sda_i};

  i2c_prom_rom #(.IMAGE(IMAGE)) u_rom (
    .rd_addr_i(addr_shift), .rd_data_o(rom_byte)
  );

  always_comb begin
    sda_d  = sda_i;
    ack_d  = ack_q;
    tick_d = tick_q;
    cmd_d  = cmd_q;
    addr_d = addr_q;
    data_d = data_q;
    if (ev == EV_START) begin
      tick_d = TICK_W'(1);
      cmd_d  = '0;
    end else if (ev == EV_STOP) begin
      // no transfer effect
    end else if (tick_q == '0 && !ack_q) begin
      // idle: wait for start
    end else if (ev == EV_BIT || ev == EV_GLITCH) begin
      if (ack_q) begin
        sda_d = 1'b0;
        ack_d = 1'b0;
      end else if (ev == EV_BIT) begin
        if (tick_q < TICK_W'(CMD_LAST)) begin
          cmd_d  = {cmd_q[BYTE_W-2:0], sda_i};
          tick_d = tick_q + 1'b1;
          if (tick_q == TICK_W'(CMD_LAST - 1)) ack_d = 1'b1;
        end else if (tick_q < TICK_W'(ADDR_LAST)) begin
          if (cmd_q[0]) sda_d = data_q[BYTE_W-1];
          addr_d = addr_shift;
          data_d = {data_q[BYTE_W-2:0], 1'b0};
          tick_d = tick_q + 1'b1;
          if (tick_q == TICK_W'(ADDR_LAST - 1)) begin
            data_d = rom_byte;
            ack_d  = 1'b1;
            tick_d = '0;
          end
        end
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_q  <= 1'b1;
      sda_q  <= 1'b1;
      ack_q  <= 1'b0;
      tick_q <= '0;
      cmd_q  <= '0;
      addr_q <= '0;
      data_q <= '0;
    end else if (upd_i) begin
      scl_q  <= scl_i;
      sda_q  <= sda_d;
      ack_q  <= ack_d;
      tick_q <= tick_d;
      cmd_q  <= cmd_d;
      addr_q <= addr_d;
      data_q <= data_d;
    end
  end

  assign sda_o      = sda_q;
  assign tick_o     = tick_q;
  assign ack_pend_o = ack_q;
  assign cmd_o      = cmd_q;
  assign addr_o     = addr_q;
  assign data_o     = data_q;

  a_r10_hold_no_upd: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !upd_i |=> $stable(tick_q) && $stable(sda_q) && $stable(cmd_q) && $stable(data_q));

  a_r2_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_i && ev == EV_START |=> tick_q == TICK_W'(1) && cmd_q == '0);

  a_r3_stop_inert: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_i && ev == EV_STOP |=> $stable(tick_q) && $stable(ack_q) && $stable(cmd_q));

  a_r5_glitch_drop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_i && !ack_q && ev == EV_GLITCH |=> $stable(tick_q) && $stable(addr_q) && $stable(cmd_q));

  a_r7_ack_drive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_i && ack_q && (ev == EV_BIT || ev == EV_GLITCH)
    |=> !ack_q && !sda_q && $stable(tick_q) && $stable(addr_q));

  a_r9_tick_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_q < TICK_W'(ADDR_LAST));
endmodule

// File: tb/i2c_prom_responder_test.sv
`timescale 1ns/1ps
module i2c_prom_responder_test;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic       rst_ni, upd_i, scl_i, sda_i, sda_o, ack_pend_o;
  logic [4:0] tick_o;
  logic [7:0] cmd_o, addr_o, data_o;

  i2c_prom_responder uut (
    .clk_i(clk), .rst_ni(rst_ni), .upd_i(upd_i), .scl_i(scl_i), .sda_i(sda_i),
    .sda_o(sda_o), .tick_o(tick_o), .ack_pend_o(ack_pend_o),
    .cmd_o(cmd_o), .addr_o(addr_o), .data_o(data_o)
  );

  typedef struct {
    bit    sda;
    int    tick;
    bit    ack;
    string tag;
  } exp_t;

  exp_t q[$];
  int   n_chk = 0, n_fail = 0;
  int   e_tick = 0;
  bit   e_ack = 0;

  function automatic logic [7:0] exp_byte(logic [7:0] a);  // R11
    return 8'((int'(a) * 7 + 1) % 256);
  endfunction

  task automatic check(bit ok, string tag, string what, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic chk8(string tag, string what, logic [7:0] act, logic [7:0] exp);
    @(negedge clk);
    check(act == exp, tag, what, int'(act), int'(exp));
  endtask

  // driver: push expectation, strobe one update
  task automatic step(bit scl, bit sda, bit es, string tag);
    @(negedge clk);
    scl_i = scl; sda_i = sda; upd_i = 1'b1;
    q.push_back('{es, e_tick, e_ack, tag});
    @(negedge clk);
    upd_i = 1'b0;
  endtask

  // monitor: compare after each strobed edge
  initial begin
    forever begin
      @(posedge clk);
      if (upd_i) begin
        #2;
        if (q.size() == 0) check(1'b0, "any", "queue empty", 0, 1);
        else begin
          exp_t it;
          it = q.pop_front();
          check(sda_o == it.sda, it.tag, "sda_o", int'(sda_o), int'(it.sda));
          check(int'(tick_o) == it.tick, it.tag, "tick_o", int'(tick_o), it.tick);
          check(ack_pend_o == it.ack, it.tag, "ack_pend_o", int'(ack_pend_o), int'(it.ack));
        end
      end
    end
  end

  task automatic do_start();
    step(1, 1, 1, "R3");
    e_tick = 1;
    step(1, 0, 0, "R2");
  endtask

  task automatic cmd_bit(bit b, bit last);
    step(0, b, b, "R5");
    e_tick++;
    if (last) e_ack = 1;
    step(1, b, b, "R6");
  endtask

  task automatic send_cmd(logic [7:0] c);
    for (int i = 7; i >= 0; i--) cmd_bit(c[i], i == 0);
  endtask

  task automatic ack_clk();
    step(0, 1, 1, "R7");
    e_ack = 0;
    step(1, 1, 0, "R7");
  endtask

  task automatic send_addr(logic [7:0] a, bit rd, logic [7:0] d);
    for (int i = 7; i >= 0; i--) begin
      step(0, a[i], a[i], "R8");
      if (i == 0) begin e_tick = 0; e_ack = 1; end
      else e_tick++;
      step(1, a[i], rd ? d[i] : a[i], "R8");
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  initial begin
    #800000;
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    rst_ni = 1'b0; upd_i = 1'b0; scl_i = 1'b1; sda_i = 1'b1;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    // R1 reset state
    @(negedge clk);
    check(sda_o == 1'b1, "R1", "sda_o", int'(sda_o), 1);
    check(tick_o == 5'd0, "R1", "tick_o", int'(tick_o), 0);
    check(ack_pend_o == 1'b0, "R1", "ack", int'(ack_pend_o), 0);
    check(cmd_o == 8'h00 && addr_o == 8'h00 && data_o == 8'h00, "R1", "regs",
          int'({cmd_o, addr_o, data_o}), 0);

    // R10: inputs move without strobe
    scl_i = 1'b1; sda_i = 1'b0;
    repeat (3) @(negedge clk);
    scl_i = 1'b0;
    repeat (2) @(negedge clk);
    check(sda_o == 1'b1 && tick_o == 5'd0, "R10", "state without strobe",
          int'({sda_o, tick_o}), 32);
    scl_i = 1'b1; sda_i = 1'b1;

    // first read: data register still zero
    do_start();
    chk8("R2", "cmd after start", cmd_o, 8'h00);
    send_cmd(8'hA1);
    chk8("R6", "cmd", cmd_o, 8'hA1);
    ack_clk();
    send_addr(8'h35, 1'b1, 8'h00);
    chk8("R8", "addr", addr_o, 8'h35);
    chk8("R9", "data fetch", data_o, exp_byte(8'h35));
    chk8("R11", "image 0x35", data_o, 8'h74);
    ack_clk();  // R7 with counter at 0

    // R4 idle activity
    step(0, 0, 0, "R4");
    step(1, 0, 0, "R4");
    step(0, 1, 1, "R4");
    step(1, 1, 1, "R4");
    chk8("R4", "cmd idle", cmd_o, 8'hA1);
    chk8("R4", "addr idle", addr_o, 8'h35);
    chk8("R4", "data idle", data_o, 8'h74);

    // R3 stop mid-command, R5 glitch
    do_start();
    cmd_bit(1, 0);
    cmd_bit(1, 0);
    cmd_bit(0, 0);
    chk8("R6", "partial cmd", cmd_o, 8'h06);
    step(1, 1, 1, "R3");
    chk8("R3", "cmd after stop", cmd_o, 8'h06);
    step(0, 1, 1, "R5");
    step(1, 0, 0, "R5");
    chk8("R5", "cmd after glitch", cmd_o, 8'h06);

    // second read: shifts out previously fetched byte
    do_start();
    send_cmd(8'hA1);
    ack_clk();
    send_addr(8'hFF, 1'b1, 8'h74);
    chk8("R8", "addr", addr_o, 8'hFF);
    chk8("R9", "data fetch", data_o, exp_byte(8'hFF));
    ack_clk();

    // write command: no override
    do_start();
    send_cmd(8'hA0);
    ack_clk();
    send_addr(8'h02, 1'b0, 8'h00);
    chk8("R8", "addr", addr_o, 8'h02);
    chk8("R11", "image 0x02", data_o, 8'h0F);
    ack_clk();

    repeat (4) @(negedge clk);
    check(q.size() == 0, "R10", "pending expectations", q.size(), 0);
    summary();
    $finish;
  end
endmodule